// File: doc/BRIEF.md
# Byte-Lane Neighbour Routing Network

This block moves one byte per processing element between the elements of a SIMD array. It keeps two wide registers, each with one byte lane per element, laid out by element number. Elements deposit their outgoing bytes into the input register. A route command then copies every byte into the lane of the output register that belongs to its destination element. After that, each element picks up its byte from its own lane of the output register.

The elements can be treated as a single line or as a grid of ROWS by COLS, numbered row-major. A line shift moves every byte one element up or down the whole array. A grid shift moves bytes one step within a row or one step within a column. An element at the edge of the pattern receives zero, or, when wraparound is requested, the byte from the far end of its own line, row or column. Arithmetic inside the elements and instruction decode are not part of this block.

Top module: `pe_route_net`

## Requirements
- R1: After reset, the output register, the input register and `rdValid` are all zero. A pass route issued right after reset returns all zeros.
- R2: Element j uses bits 8j to 8j+7 of `wrData` and of `rdData`. Elements are numbered row-major, so element j sits in row j/COLS and column j%COLS.
- R3: A write (`wrEn`=1) loads lane j of the input register only when `peActive[j]`=1. Lanes whose element is inactive keep their previous contents.
- R4: Route code 1 (line right) gives lane j+1 the byte from input lane j. Lane 0 receives zero, or input lane N-1 when `wrapEn`=1.
- R5: Route code 0 (line left) gives lane j-1 the byte from input lane j. Lane N-1 receives zero, or input lane 0 when `wrapEn`=1.
- R6: Route code 4 (east) moves bytes one column right, and route code 5 (west) moves them one column left, always staying inside their row. The edge column of the row receives zero, or, with `wrapEn`=1, the byte from the opposite end of the same row.
- R7: Route code 3 (south) moves a byte from lane j to lane j+COLS, and route code 2 (north) moves it from lane j to lane j-COLS. The edge row receives zero, or, with `wrapEn`=1, the byte from the opposite row of the same column.
- R8: Route codes 6 and 7 (pass) copy every input lane to the same output lane.
- R9: The output register takes its new value at the clock edge that samples `routeGo`=1. `rdValid` is high for exactly the following cycle. Without a route command, `rdData` holds its value and `rdValid` is low.
- R10: When a write and a route are issued in the same cycle, the route uses the input register contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Load active lanes of the input register |
| peActive | input | ROWS*COLS | Per-element activity mask for writes |
| wrData | input | 8*ROWS*COLS | Outgoing bytes, lane j at bits 8j..8j+7 |
| routeGo | input | 1 | Route command |
| routeDir | input | 3 | Route code: 0 left, 1 right, 2 north, 3 south, 4 east, 5 west, 6/7 pass |
| wrapEn | input | 1 | Edge lanes take the byte from the far end instead of zero |
| rdData | output | 8*ROWS*COLS | Output register, lane j at bits 8j..8j+7 |
| rdValid | output | 1 | High for the cycle after a route command |

## Verification
The bench builds the block with a grid of 3 rows by 4 columns. The row and column counts differ, so any mix-up between a row step and a column step shows up as a mismatch. A row-bounded east or west shift gives a different result from a whole-array line shift at lanes 3, 4, 7 and 8, so the two can be told apart. With twelve lanes, random masks and data quickly cover every edge lane, with and without wraparound. Write and route are also issued in the same cycle, which checks that the route reads the input register as it was before the write.

// File: rtl/pe_route_pkg.sv
package pe_route_pkg;

  typedef enum logic [2:0] {
    DIR_LEFT  = 3'd0,
    DIR_RIGHT = 3'd1,
    DIR_NORTH = 3'd2,
    DIR_SOUTH = 3'd3,
    DIR_EAST  = 3'd4,
    DIR_WEST  = 3'd5,
    DIR_PASSA = 3'd6,
    DIR_PASSB = 3'd7
  } routeDir_e;

  typedef struct packed {
    logic      loadIn;
    logic      routeNow;
    logic      wrap;
    routeDir_e dir;
  } ctrlStrobes_t;

endpackage

// File: rtl/pe_route_ctrl.sv
module pe_route_ctrl
  import pe_route_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic         routeGo,
  input  logic [2:0]   routeDir,
  input  logic         wrapEn,
  output ctrlStrobes_t strb,
  output logic         rdValid
);

  always_comb begin
    strb.loadIn   = wrEn;
    strb.routeNow = routeGo;
    strb.wrap     = wrapEn;
    strb.dir      = routeDir_e'(routeDir);
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= routeGo;
  end

endmodule

// File: rtl/pe_route_dp.sv
module pe_route_dp
  import pe_route_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int LANE_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobes_t               strb,
  input  logic [ROWS*COLS-1:0]       peActive,
  input  logic [ROWS*COLS*LANE_W-1:0] wrData,
  output logic [ROWS*COLS*LANE_W-1:0] inView,
  output logic [ROWS*COLS*LANE_W-1:0] rdData
);

  localparam int NUM_PE = ROWS * COLS;
  localparam int BUS_W  = NUM_PE * LANE_W;

  logic [BUS_W-1:0] inReg;
  logic [BUS_W-1:0] outReg;
  logic [BUS_W-1:0] routed;

  genvar d;
  generate
    for (d = 0; d < NUM_PE; d++) begin : g_lane
      localparam int ROW = d / COLS;
      localparam int COL = d % COLS;
      // source lane and edge flag for each direction
      localparam int  SRC_R  = (d > 0) ? d - 1 : NUM_PE - 1;
      localparam bit  EDGE_R = (d == 0);
      localparam int  SRC_L  = (d < NUM_PE - 1) ? d + 1 : 0;
      localparam bit  EDGE_L = (d == NUM_PE - 1);
      localparam int  SRC_E  = (COL > 0) ? d - 1 : ROW * COLS + COLS - 1;
      localparam bit  EDGE_E = (COL == 0);
      localparam int  SRC_W  = (COL < COLS - 1) ? d + 1 : ROW * COLS;
      localparam bit  EDGE_W = (COL == COLS - 1);
      localparam int  SRC_S  = (ROW > 0) ? d - COLS : d + (ROWS - 1) * COLS;
      localparam bit  EDGE_S = (ROW == 0);
      localparam int  SRC_N  = (ROW < ROWS - 1) ? d + COLS : COL;
      localparam bit  EDGE_N = (ROW == ROWS - 1);

      logic [LANE_W-1:0] laneVal;

      always_comb begin
        case (strb.dir)
          DIR_RIGHT: laneVal = (EDGE_R && !strb.wrap) ? '0 : inReg[SRC_R*LANE_W +: LANE_W];
          DIR_LEFT:  laneVal = (EDGE_L && !strb.wrap) ? '0 : inReg[SRC_L*LANE_W +: LANE_W];
          DIR_EAST:  laneVal = (EDGE_E && !strb.wrap) ? '0 : inReg[SRC_E*LANE_W +: LANE_W];
          DIR_WEST:  laneVal = (EDGE_W && !strb.wrap) ? '0 : inReg[SRC_W*LANE_W +: LANE_W];
          DIR_SOUTH: laneVal = (EDGE_S && !strb.wrap) ? '0 : inReg[SRC_S*LANE_W +: LANE_W];
          DIR_NORTH: laneVal = (EDGE_N && !strb.wrap) ? '0 : inReg[SRC_N*LANE_W +: LANE_W];
          default:   laneVal = inReg[d*LANE_W +: LANE_W];
        endcase
      end

      assign routed[d*LANE_W +: LANE_W] = laneVal;

      always_ff @(posedge clk) begin
        if (!rstN)
          inReg[d*LANE_W +: LANE_W] <= '0;
        else if (strb.loadIn && peActive[d])
          inReg[d*LANE_W +: LANE_W] <= wrData[d*LANE_W +: LANE_W];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)              outReg <= '0;
    else if (strb.routeNow) outReg <= routed;
  end

  assign inView = inReg;
  assign rdData = outReg;

endmodule

// File: rtl/pe_route_net.sv
module pe_route_net
  import pe_route_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int LANE_W = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic [ROWS*COLS-1:0]        peActive,
  input  logic [ROWS*COLS*LANE_W-1:0] wrData,
  input  logic                        routeGo,
  input  logic [2:0]                  routeDir,
  input  logic                        wrapEn,
  output logic [ROWS*COLS*LANE_W-1:0] rdData,
  output logic                        rdValid
);

  ctrlStrobes_t                  strb;
  logic [ROWS*COLS*LANE_W-1:0]   inView;

  pe_route_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .routeGo (routeGo),
    .routeDir(routeDir),
    .wrapEn  (wrapEn),
    .strb    (strb),
    .rdValid (rdValid)
  );

  pe_route_dp #(.ROWS(ROWS), .COLS(COLS), .LANE_W(LANE_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .peActive(peActive),
    .wrData  (wrData),
    .inView  (inView),
    .rdData  (rdData)
  );

endmodule

// File: rtl/pe_route_net_chk.sv
module pe_route_net_chk #(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int LANE_W = 8
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        wrEn,
  input logic [ROWS*COLS-1:0]        peActive,
  input logic                        routeGo,
  input logic [2:0]                  routeDir,
  input logic                        wrapEn,
  input logic [ROWS*COLS*LANE_W-1:0] inView,
  input logic [ROWS*COLS*LANE_W-1:0] rdData,
  input logic                        rdValid
);

  AST_VALID_AFTER_ROUTE: assert property (@(posedge clk) disable iff (!rstN)
    routeGo |=> rdValid);  // R9
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !routeGo |=> !rdValid);  // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !routeGo |=> $stable(rdData));  // R9
  AST_PASS_COPY: assert property (@(posedge clk) disable iff (!rstN)
    (routeGo && routeDir[2:1] == 2'b11) |=> rdData == $past(inView));  // R8
  AST_RIGHT_LANE1: assert property (@(posedge clk) disable iff (!rstN)
    (routeGo && routeDir == 3'd1) |=> rdData[2*LANE_W-1:LANE_W] == $past(inView[LANE_W-1:0]));  // R4
  AST_RIGHT_EDGE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (routeGo && routeDir == 3'd1 && !wrapEn) |=> rdData[LANE_W-1:0] == '0);  // R4
  AST_INACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !peActive[0]) |=> inView[LANE_W-1:0] == $past(inView[LANE_W-1:0]));  // R3

endmodule

bind pe_route_net pe_route_net_chk #(.ROWS(ROWS), .COLS(COLS), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .peActive(peActive), .routeGo(routeGo),
  .routeDir(routeDir), .wrapEn(wrapEn), .inView(inView), .rdData(rdData), .rdValid(rdValid)
);

// File: tb/pe_route_net_bench.sv
module pe_route_net_bench;

  localparam int ROWS = 3;
  localparam int COLS = 4;
  localparam int N    = ROWS * COLS;
  localparam int W    = 8 * N;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [N-1:0] peActive = '0;
  logic [W-1:0] wrData = '0;
  logic         routeGo = 1'b0;
  logic [2:0]   routeDir = 3'd0;
  logic         wrapEn = 1'b0;
  logic [W-1:0] rdData;
  logic         rdValid;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;
  string curReq = "R1";

  int refIn [N];
  int refOut [N];
  bit refValid;

  always #10 clk = ~clk;

  pe_route_net #(.ROWS(ROWS), .COLS(COLS), .LANE_W(8)) u_pe_route_net (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .peActive(peActive), .wrData(wrData),
    .routeGo(routeGo), .routeDir(routeDir), .wrapEn(wrapEn),
    .rdData(rdData), .rdValid(rdValid)
  );

  // Destination-centred reference: which byte lands in lane d
  function automatic int refRoute(int dir, bit wrap, int d);
    int r = d / COLS;
    int c = d % COLS;
    case (dir)
      1: return (d == 0) ? (wrap ? refIn[N-1] : 0) : refIn[d-1];
      0: return (d == N-1) ? (wrap ? refIn[0] : 0) : refIn[d+1];
      4: return (c == 0) ? (wrap ? refIn[r*COLS+COLS-1] : 0) : refIn[d-1];
      5: return (c == COLS-1) ? (wrap ? refIn[r*COLS] : 0) : refIn[d+1];
      3: return (r == 0) ? (wrap ? refIn[(ROWS-1)*COLS+c] : 0) : refIn[d-COLS];
      2: return (r == ROWS-1) ? (wrap ? refIn[c] : 0) : refIn[d+COLS];
      default: return refIn[d];
    endcase
  endfunction

  always @(posedge clk) begin
    int nxt [N];
    if (!rstN) begin
      foreach (refIn[i]) begin refIn[i] = 0; refOut[i] = 0; end
      refValid = 0;
    end else begin
      foreach (nxt[i]) nxt[i] = refRoute(int'(routeDir), wrapEn, i);
      if (routeGo) foreach (refOut[i]) refOut[i] = nxt[i];
      refValid = routeGo;
      if (wrEn)
        for (int i = 0; i < N; i++)
          if (peActive[i]) refIn[i] = int'(wrData[8*i +: 8]);
    end
  end

  always @(negedge clk) begin
    logic [W-1:0] expOut;
    if (!finished) begin
      for (int i = 0; i < N; i++) expOut[8*i +: 8] = refOut[i][7:0];
      testsRun++;
      if (rdData !== expOut || rdValid !== refValid) begin
        testsFailed++;
        $display("FAIL %s: rdData=%h rdValid=%b expected rdData=%h rdValid=%b",
                 curReq, rdData, rdValid, expOut, refValid);
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wrEn = 0; routeGo = 0;
    end
  endtask

  task automatic doWrite(logic [N-1:0] mask, logic [W-1:0] data);
    @(negedge clk);
    wrEn = 1; routeGo = 0; peActive = mask; wrData = data;
  endtask

  task automatic doRoute(int dir, bit wrap);
    @(negedge clk);
    wrEn = 0; routeGo = 1; routeDir = 3'(dir); wrapEn = wrap;
  endtask

  function automatic logic [W-1:0] ramp(int base);
    logic [W-1:0] v;
    for (int i = 0; i < N; i++) v[8*i +: 8] = 8'(base + i);
    return v;
  endfunction

  initial begin
    #(20 * 200000);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: run did not finish");
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    curReq = "R1";
    repeat (3) @(negedge clk);
    rstN = 1;
    doRoute(6, 0);           // R1 pass after reset gives zeros
    idle(2);

    curReq = "R2";           // R2 lane layout via ramp and pass
    doWrite('1, ramp(8'h10));
    doRoute(7, 0);
    idle(1);

    curReq = "R4";
    doRoute(1, 0); idle(1);
    doRoute(1, 1); idle(1);
    curReq = "R5";
    doRoute(0, 0); idle(1);
    doRoute(0, 1); idle(1);
    curReq = "R6";
    doRoute(4, 0); idle(1);
    doRoute(4, 1); idle(1);
    doRoute(5, 0); idle(1);
    doRoute(5, 1); idle(1);
    curReq = "R7";
    doRoute(3, 0); idle(1);
    doRoute(3, 1); idle(1);
    doRoute(2, 0); idle(1);
    doRoute(2, 1); idle(1);

    curReq = "R3";           // partial mask, then pass to expose held lanes
    doWrite(12'b1010_0110_0011, ramp(8'hA0));
    doRoute(6, 0); idle(1);
    doWrite('0, ramp(8'h55));
    doRoute(7, 0); idle(1);

    curReq = "R10";          // write and route together
    @(negedge clk);
    wrEn = 1; peActive = '1; wrData = ramp(8'hC0);
    routeGo = 1; routeDir = 3'd1; wrapEn = 1;
    idle(1);
    doRoute(6, 0);

    curReq = "R9";           // holding with no command
    idle(5);

    curReq = "R8";
    for (int k = 0; k < 120; k++) begin
      @(negedge clk);
      wrEn = 1'($urandom);
      peActive = N'($urandom);
      for (int i = 0; i < N; i++) wrData[8*i +: 8] = 8'($urandom);
      routeGo = 1'($urandom);
      routeDir = 3'($urandom);
      wrapEn = 1'($urandom);
      curReq = (routeDir[2:1] == 2'b11) ? "R8" : "R6";
    end
    idle(3);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule